// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor's execute stage. Up to seven exception sources can raise a request in the same cycle: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It masks the two interrupt sources with the interrupt-disable bits of the current status word, picks one winner by fixed priority, and in the next cycle presents the complete entry update.

The entry update has several parts. It gives the new program counter, which is the vector address. It gives the return link, which is the current PC plus four, for the link register of the target mode. It gives a write strobe and data that copy the current status word into the saved status register of that mode. It also gives the new mode and the new status word with its interrupt masks. The register file that takes these values and the instruction decode that raises the requests are outside this block.

The status word layout used here has the mode in bits [4:0], the instruction-set state bit T in bit 5, the fast-interrupt disable F in bit 6 and the interrupt disable I in bit 7. The mode codes are 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort and 0x1B undefined.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero in the following cycle, even with requests active.
- R2: When at least one effective request is present, `entry_valid` is high in the next cycle. The winner follows this priority from highest to lowest: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R3: `next_pc` is VEC_BASE plus the winner's offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, interrupt 0x18, fast interrupt 0x1C. Offset 0x14 is never produced.
- R4: `new_mode` is 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for either abort, 0x12 for interrupt and 0x11 for fast interrupt.
- R5: On entry, `link_val` equals the `cur_pc` sampled at the request edge plus LINK_OFS (default 4).
- R6: On entry, `spsr_we` is high and `spsr_data` equals the `cur_psr` sampled at the request edge.
- R7: On entry, `new_cpsr` equals the sampled `cur_psr` with these changes: bits [4:0] become the new mode, T (bit 5) is 0, I (bit 7) is 1, and F (bit 6) is 1 for reset and fast interrupt entries and unchanged for all others. `mask_irq` and `mask_fiq` equal bits 7 and 6 of `new_cpsr`.
- R8: An interrupt request is ignored while `cur_psr` bit 7 is set, and a fast-interrupt request is ignored while `cur_psr` bit 6 is set.
- R9: If undefined and software interrupt are requested together with no higher source, undefined wins.
- R10: In a cycle with no entry, `entry_valid`, `spsr_we`, `mask_irq` and `mask_fiq` are 0 and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software-interrupt request |
| req_pabt | input | 1 | Prefetch-abort request |
| req_dabt | input | 1 | Data-abort request |
| req_irq | input | 1 | Interrupt request, maskable by I |
| req_fiq | input | 1 | Fast-interrupt request, maskable by F |
| cur_pc | input | ADDR_W | Current program counter |
| cur_psr | input | 32 | Current status word |
| entry_valid | output | 1 | Entry update valid this cycle |
| next_pc | output | ADDR_W | Vector address to load into PC |
| link_val | output | ADDR_W | Return address for the target mode's link register |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_data | output | 32 | Status word to save |
| new_mode | output | 5 | Target mode code |
| new_cpsr | output | 32 | Status word after entry |
| mask_irq | output | 1 | Interrupt mask after entry |
| mask_fiq | output | 1 | Fast-interrupt mask after entry |

## Verification
The case hardest to reach from the ports is a lower-priority source winning because every higher source is either idle or blocked by a status-word mask. An example is a prefetch abort winning over a masked fast interrupt and a masked interrupt. The stimulus reaches these cases by sweeping all 128 request sets against all four combinations of the I and F bits. The current mode, the T bit and the PC vary across the sweep, so the saved status and link values differ from one entry to the next. Reset is also asserted in the middle of the run while requests are active.

// File: rtl/exc_pkg.sv
// Package: shared encodings and per-source constants for exception entry.
// Assumes a 32-bit status word with mode in [4:0], T in 5, F in 6, I in 7.
package exc_pkg;

    localparam int unsigned NUM_SRC = 7;
    localparam int unsigned PSR_W   = 32;
    localparam int unsigned MODE_W  = 5;
    localparam int unsigned OFS_W   = 8;

    // Source index in the request vector
    localparam int unsigned SRC_RESET = 0;
    localparam int unsigned SRC_UNDEF = 1;
    localparam int unsigned SRC_SWI   = 2;
    localparam int unsigned SRC_PABT  = 3;
    localparam int unsigned SRC_DABT  = 4;
    localparam int unsigned SRC_IRQ   = 5;
    localparam int unsigned SRC_FIQ   = 6;

    localparam int unsigned PSR_T = 5;
    localparam int unsigned PSR_F = 6;
    localparam int unsigned PSR_I = 7;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

    // Rank of a source: 0 is served first
    function automatic int unsigned src_rank(input int unsigned s);
        case (s)
            SRC_RESET: return 0;
            SRC_DABT:  return 1;
            SRC_FIQ:   return 2;
            SRC_IRQ:   return 3;
            SRC_PABT:  return 4;
            SRC_UNDEF: return 5;
            default:   return 6;
        endcase
    endfunction

    // Set of sources that outrank source s
    function automatic logic [NUM_SRC-1:0] higher_mask(input int unsigned s);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int unsigned j = 0; j < NUM_SRC; j++) begin
            if (src_rank(j) < src_rank(s)) m[j] = 1'b1;
        end
        return m;
    endfunction

    // Vector offset: 4 bytes per source, slot 0x14 skipped
    function automatic logic [OFS_W-1:0] vec_offset(input int unsigned s);
        int unsigned o;
        o = (s < SRC_IRQ) ? s * 4 : s * 4 + 4;
        return OFS_W'(o);
    endfunction

    function automatic logic [MODE_W-1:0] src_mode(input int unsigned s);
        case (s)
            SRC_RESET, SRC_SWI: return MODE_SVC;
            SRC_UNDEF:          return MODE_UND;
            SRC_PABT, SRC_DABT: return MODE_ABT;
            SRC_IRQ:            return MODE_IRQ;
            default:            return MODE_FIQ;
        endcase
    endfunction

    function automatic logic src_sets_f(input int unsigned s);
        return (s == SRC_RESET) || (s == SRC_FIQ);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
// Module: fixed-priority arbiter over the effective exception requests.
// Assumes requests are already masked; produces a one-hot or empty grant.
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o
);

    // One grant term per source: granted when no outranking source requests
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [NUM_SRC-1:0] OUTRANK = higher_mask(g);
        assign grant_o[g] = req_i[g] & ~|(req_i & OUTRANK);
    end

endmodule

// File: rtl/exc_vector_map.sv
// Module: turns a one-hot grant into vector, mode and new status word.
// Assumes grant_i is one-hot or zero; output is meaningless when zero.
module exc_vector_map
    import exc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic [NUM_SRC-1:0] grant_i,
    input  logic [PSR_W-1:0]   cur_psr_i,
    output logic [ADDR_W-1:0]  vec_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [PSR_W-1:0]   new_psr_o
);

    logic [OFS_W-1:0] ofs;
    logic             set_f;

    // Merge the per-source constants of the granted source
    always_comb begin
        ofs    = '0;
        mode_o = '0;
        set_f  = 1'b0;
        for (int unsigned i = 0; i < NUM_SRC; i++) begin
            if (grant_i[i]) begin
                ofs    = ofs | vec_offset(i);
                mode_o = mode_o | src_mode(i);
                set_f  = set_f | src_sets_f(i);
            end
        end
    end

    assign vec_o = VEC_BASE + ADDR_W'(ofs);

    // Build the post-entry status word from the current one
    always_comb begin
        new_psr_o               = cur_psr_i;
        new_psr_o[MODE_W-1:0]   = mode_o;
        new_psr_o[PSR_T]        = 1'b0;
        new_psr_o[PSR_I]        = 1'b1;
        new_psr_o[PSR_F]        = cur_psr_i[PSR_F] | set_f;
    end

endmodule

// File: rtl/exc_entry_regs.sv
// Module: output registers holding the one-cycle entry update.
// Assumes take_i qualifies all data inputs; idle cycles drive zeros.
module exc_entry_regs
    import exc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic [ADDR_W-1:0]  vec_i,
    input  logic [ADDR_W-1:0]  link_i,
    input  logic [PSR_W-1:0]   old_psr_i,
    input  logic [PSR_W-1:0]   new_psr_i,
    input  logic [MODE_W-1:0]  mode_i,
    output logic               valid_o,
    output logic [ADDR_W-1:0]  next_pc_o,
    output logic [ADDR_W-1:0]  link_o,
    output logic               spsr_we_o,
    output logic [PSR_W-1:0]   spsr_data_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [PSR_W-1:0]   new_psr_o,
    output logic               mask_irq_o,
    output logic               mask_fiq_o
);

    // Capture the entry update, or clear everything when idle or in reset
    always_ff @(posedge clk) begin
        if (!rst_n || !take_i) begin
            valid_o     <= 1'b0;
            next_pc_o   <= '0;
            link_o      <= '0;
            spsr_we_o   <= 1'b0;
            spsr_data_o <= '0;
            mode_o      <= '0;
            new_psr_o   <= '0;
            mask_irq_o  <= 1'b0;
            mask_fiq_o  <= 1'b0;
        end else begin
            valid_o     <= 1'b1;
            next_pc_o   <= vec_i;
            link_o      <= link_i;
            spsr_we_o   <= 1'b1;
            spsr_data_o <= old_psr_i;
            mode_o      <= mode_i;
            new_psr_o   <= new_psr_i;
            mask_irq_o  <= new_psr_i[PSR_I];
            mask_fiq_o  <= new_psr_i[PSR_F];
        end
    end

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (next_pc_o == '0 && !spsr_we_o && !mask_irq_o && !mask_fiq_o));

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: top of the exception entry controller. Masks interrupt requests,
// arbitrates, maps the winner and registers the entry update one cycle later.
// Assumes cur_pc and cur_psr are valid in the cycle the requests are sampled.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    parameter logic [ADDR_W-1:0] LINK_OFS = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic              req_pabt,
    input  logic              req_dabt,
    input  logic              req_irq,
    input  logic              req_fiq,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [31:0]       cur_psr,
    output logic              entry_valid,
    output logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] link_val,
    output logic              spsr_we,
    output logic [31:0]       spsr_data,
    output logic [4:0]        new_mode,
    output logic [31:0]       new_cpsr,
    output logic              mask_irq,
    output logic              mask_fiq
);

    logic [NUM_SRC-1:0] eff_req;
    logic [NUM_SRC-1:0] grant;
    logic [ADDR_W-1:0]  vec;
    logic [MODE_W-1:0]  mode;
    logic [PSR_W-1:0]   psr_after;

    // Gather requests, dropping interrupts the status word disables
    always_comb begin
        eff_req            = '0;
        eff_req[SRC_RESET] = req_reset;
        eff_req[SRC_UNDEF] = req_undef;
        eff_req[SRC_SWI]   = req_swi;
        eff_req[SRC_PABT]  = req_pabt;
        eff_req[SRC_DABT]  = req_dabt;
        eff_req[SRC_IRQ]   = req_irq & ~cur_psr[PSR_I];
        eff_req[SRC_FIQ]   = req_fiq & ~cur_psr[PSR_F];
    end

    exc_arbiter i_arb (
        .req_i   (eff_req),
        .grant_o (grant)
    );

    exc_vector_map #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) i_map (
        .grant_i   (grant),
        .cur_psr_i (cur_psr),
        .vec_o     (vec),
        .mode_o    (mode),
        .new_psr_o (psr_after)
    );

    exc_entry_regs #(
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (|grant),
        .vec_i       (vec),
        .link_i      (cur_pc + LINK_OFS),
        .old_psr_i   (cur_psr),
        .new_psr_i   (psr_after),
        .mode_i      (mode),
        .valid_o     (entry_valid),
        .next_pc_o   (next_pc),
        .link_o      (link_val),
        .spsr_we_o   (spsr_we),
        .spsr_data_o (spsr_data),
        .mode_o      (new_mode),
        .new_psr_o   (new_cpsr),
        .mask_irq_o  (mask_irq),
        .mask_fiq_o  (mask_fiq)
    );

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|grant) == (|eff_req)));

    assert_vec_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (next_pc != VEC_BASE + ADDR_W'(8'h14)));

    assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (link_val == $past(cur_pc) + LINK_OFS));

    assert_spsr_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (spsr_we && spsr_data == $past(cur_psr)));

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> (mask_irq && !new_cpsr[PSR_T] && new_cpsr[4:0] == new_mode));

    assert_irq_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_irq && cur_psr[PSR_I] && !req_reset && !req_undef && !req_swi
         && !req_pabt && !req_dabt && !req_fiq) |=> !entry_valid);

    assert_undef_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_undef && req_swi && !req_reset && !req_pabt && !req_dabt
         && !(req_irq && !cur_psr[PSR_I]) && !(req_fiq && !cur_psr[PSR_F]))
        |=> (new_mode == MODE_UND));

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  req = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_psr = '0;
    logic        entry_valid, spsr_we, mask_irq, mask_fiq;
    logic [31:0] next_pc, link_val, spsr_data, new_cpsr;
    logic [4:0]  new_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_reset (req[0]), .req_undef (req[1]), .req_swi (req[2]),
        .req_pabt (req[3]), .req_dabt (req[4]), .req_irq (req[5]), .req_fiq (req[6]),
        .cur_pc (cur_pc), .cur_psr (cur_psr),
        .entry_valid (entry_valid), .next_pc (next_pc), .link_val (link_val),
        .spsr_we (spsr_we), .spsr_data (spsr_data), .new_mode (new_mode),
        .new_cpsr (new_cpsr), .mask_irq (mask_irq), .mask_fiq (mask_fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_mode(input int s);
        case (s)
            0, 2: return 5'h13;
            1:    return 5'h1B;
            3, 4: return 5'h17;
            5:    return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    // Watchdog: an expired run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ord[7] = '{0, 4, 6, 5, 3, 1, 2};
        // R1: reset held with requests active
        req = 7'h7F;
        cur_pc = 32'h1234;
        cur_psr = 32'h10;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'b0, entry_valid}, 32'h0);
        chk("R1 next_pc", next_pc, 32'h0);
        chk("R1 spsr_we", {31'b0, spsr_we}, 32'h0);
        chk("R1 new_cpsr", new_cpsr, 32'h0);
        rst_n = 1'b1;
        for (int r = 0; r < 128; r++) begin
            for (int m = 0; m < 4; m++) begin
                logic [6:0]  eff;
                logic [31:0] psr, pc, ex_psr;
                int          win;
                psr = 32'h6000_0000 | (32'(m) << 6) | (r[1] ? 32'h20 : 32'h0)
                      | (r[2] ? 32'h10 : 32'h13);
                pc  = 32'h0000_4000 + 32'(r) * 256 + 32'(m) * 4;
                @(negedge clk);
                req = 7'(r);
                cur_pc = pc;
                cur_psr = psr;
                @(negedge clk);
                eff = 7'(r);
                if (psr[7]) eff[5] = 1'b0;
                if (psr[6]) eff[6] = 1'b0;
                win = -1;
                for (int k = 6; k >= 0; k--) if (eff[ord[k]]) win = ord[k];
                if (win < 0) begin
                    chk((r == 32 && psr[7]) || (r == 64 && psr[6]) ? "R8 masked" : "R10 valid",
                        {31'b0, entry_valid}, 32'h0);
                    chk("R10 next_pc", next_pc, 32'h0);
                    chk("R10 spsr_we", {31'b0, spsr_we}, 32'h0);
                    chk("R10 masks", {30'b0, mask_irq, mask_fiq}, 32'h0);
                end else begin
                    chk("R2 valid", {31'b0, entry_valid}, 32'h1);
                    chk("R3 vector", next_pc, 32'((win < 5) ? win * 4 : win * 4 + 4));
                    chk(((r & 7'h7B) == 7'h06) ? "R9 undef wins" : "R4 mode",
                        {27'b0, new_mode}, {27'b0, exp_mode(win)});
                    chk("R5 link", link_val, pc + 32'd4);
                    chk("R6 spsr", spsr_data, psr);
                    chk("R6 spsr_we", {31'b0, spsr_we}, 32'h1);
                    ex_psr = psr;
                    ex_psr[4:0] = exp_mode(win);
                    ex_psr[5] = 1'b0;
                    ex_psr[7] = 1'b1;
                    if (win == 0 || win == 6) ex_psr[6] = 1'b1;
                    chk("R7 new_cpsr", new_cpsr, ex_psr);
                    chk("R7 masks", {30'b0, mask_irq, mask_fiq}, {30'b0, 1'b1, ex_psr[6]});
                end
            end
        end
        // R1: reset in mid-run with requests present
        @(negedge clk);
        rst_n = 1'b0;
        req = 7'h10;
        cur_psr = 32'h10;
        @(negedge clk);
        chk("R1 mid reset valid", {31'b0, entry_valid}, 32'h0);
        chk("R1 mid reset link", link_val, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 dabt after reset", next_pc, 32'h10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule